// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO controller

This block is a general-purpose I/O controller for 32 pins, reached through a small 32-bit register bus. Input pins pass through a two-stage synchronizer. The block then detects rising and falling edges and high and low levels on them. Each of these four conditions has its own sticky pending set and its own enable mask. Every enabled pending bit feeds one shared interrupt line.

Output pins are driven with the output value masked by the output enable, then inverted bit-wise by an invert mask. The invert therefore still acts on pins whose output is disabled. Pull-up and drive-strength masks are only held and read back; their electrical effect belongs to the pad ring.

Software clears pending bits by writing ones to them. The bus accepts one access on every cycle. It has no back-pressure: there is no ready signal, and a request presented with `req_valid` high is always taken. Read data comes back one cycle later, flagged by `rsp_valid`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `pins_out` is zero. Input enable (0x04), output enable (0x08), output value (0x0C), pull-up mask (0x10), drive mask (0x14), the enable masks for rise (0x18), fall (0x20), high (0x28) and low (0x30), and the invert mask (0x40) read back the last word written to them.
- R2: A read at 0x00 returns the pin levels as seen after a two-flop synchronizer, ANDed with the input enable. A pin change that settles before a clock edge is not yet visible to a read request sampled at that same edge.
- R3: The rise pending set (0x1C) gains bit i when synchronized pin i goes from 0 to 1 while input enable bit i is 1. The fall pending set (0x24) gains bit i on a 1-to-0 change under the same condition. No edge is reported for a pin whose input enable is 0.
- R4: The high pending set (0x2C) gains bit i on every cycle in which enabled pin i is seen at 1. The low pending set (0x34) gains bit i on every cycle in which enabled pin i is seen at 0.
- R5: Pending bits stay set until software clears them. A write to a pending register clears exactly the bits written as 1. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: `irq` is high exactly when some pending bit of any of the four sets has its matching enable bit set.
- R7: `pins_out` equals (output value AND output enable) XOR invert mask. It changes only in the cycle after a register write.
- R8: A read of an unmapped offset, or of an address whose two low bits are not zero, returns zero. Writes to such addresses, and writes to 0x00, change no register.
- R9: A read request taken at one clock edge sets `rsp_valid` high with its data for exactly the following cycle. A write request, or an idle cycle, leaves `rsp_valid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address inside the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pins_in | input | 32 | Asynchronous pin levels |
| pins_out | output | 32 | Driven pin values |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `req_valid`, `req_write`, `req_addr` and `req_wdata` are stable at the clock edge. They also assume that pending bits can fall only through a bus write to their own address.

The bench changes `pins_in` only on falling clock edges. It then holds the pins for at least four cycles before comparing results, so every edge has passed the synchronizer and set its pending bit before the checks are made. Every register write is followed by two idle cycles, so level pending bits that a new input enable exposes are already set when the bench compares `irq` and read data.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W  = 7;
  localparam int unsigned NUM_KINDS   = 4;
  localparam int unsigned SYNC_STAGES = 2;

  // condition kinds, index into the enable and pending arrays
  localparam int K_RISE = 0;
  localparam int K_FALL = 1;
  localparam int K_HIGH = 2;
  localparam int K_LOW  = 3;

  localparam logic [REG_ADDR_W-1:0] OFS_LEVEL = 7'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_IN_EN = 7'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_OE    = 7'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_OVAL  = 7'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_PULL  = 7'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_DRIVE = 7'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_INV   = 7'h40;

  // enable mask of kind k sits at 0x18 + 8k, its pending set 4 bytes above
  function automatic logic [REG_ADDR_W-1:0] ie_ofs(input int k);
    return REG_ADDR_W'(24 + 8 * k);
  endfunction

  function automatic logic [REG_ADDR_W-1:0] pend_ofs(input int k);
    return REG_ADDR_W'(28 + 8 * k);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= raw_i;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [REG_ADDR_W-1:0] req_addr,
  input  logic [N_PINS-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [N_PINS-1:0]     rsp_rdata,
  input  logic [N_PINS-1:0]     pins_in,
  output logic [N_PINS-1:0]     pins_out,
  output logic                  irq
);
  logic aligned, wr_hit, rd_hit;
  logic [N_PINS-1:0] in_en_q, oe_q, oval_q, pull_q, drive_q, inv_q;
  logic [NUM_KINDS-1:0][N_PINS-1:0] ie_q, pend_q, set_v, clr_v;
  logic [N_PINS-1:0] lvl, rise, fall;
  logic [N_PINS-1:0] rd_mux;
  logic any_irq;

  assign aligned = (req_addr[1:0] == 2'b00);
  assign wr_hit  = req_valid &&  req_write && aligned;
  assign rd_hit  = req_valid && !req_write;

  gpio_in_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pins_in),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en_q <= '0; oe_q <= '0; oval_q <= '0;
      pull_q  <= '0; drive_q <= '0; inv_q <= '0;
      ie_q    <= '0;
    end else if (wr_hit) begin
      case (req_addr)
        OFS_IN_EN: in_en_q <= req_wdata;
        OFS_OE:    oe_q    <= req_wdata;
        OFS_OVAL:  oval_q  <= req_wdata;
        OFS_PULL:  pull_q  <= req_wdata;
        OFS_DRIVE: drive_q <= req_wdata;
        OFS_INV:   inv_q   <= req_wdata;
        default: ;
      endcase
      for (int k = 0; k < int'(NUM_KINDS); k++)
        if (req_addr == ie_ofs(k)) ie_q[k] <= req_wdata;
    end
  end

  assign set_v[K_RISE] = rise & in_en_q;
  assign set_v[K_FALL] = fall & in_en_q;
  assign set_v[K_HIGH] = lvl & in_en_q;
  assign set_v[K_LOW]  = ~lvl & in_en_q;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign clr_v[k] = (wr_hit && req_addr == pend_ofs(k)) ? req_wdata : '0;
    gpio_pend_bank #(.W(N_PINS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_v[k]), .clr_i(clr_v[k]), .pend_o(pend_q[k])
    );
  end

  always_comb begin
    any_irq = 1'b0;
    for (int k = 0; k < int'(NUM_KINDS); k++)
      any_irq = any_irq | (|(pend_q[k] & ie_q[k]));
  end
  assign irq = any_irq;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (req_addr)
        OFS_LEVEL: rd_mux = lvl & in_en_q;
        OFS_IN_EN: rd_mux = in_en_q;
        OFS_OE:    rd_mux = oe_q;
        OFS_OVAL:  rd_mux = oval_q;
        OFS_PULL:  rd_mux = pull_q;
        OFS_DRIVE: rd_mux = drive_q;
        OFS_INV:   rd_mux = inv_q;
        default:   rd_mux = '0;
      endcase
      for (int k = 0; k < int'(NUM_KINDS); k++) begin
        if (req_addr == ie_ofs(k))   rd_mux = ie_q[k];
        if (req_addr == pend_ofs(k)) rd_mux = pend_q[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rd_hit) rsp_rdata <= rd_mux;
    end
  end

  assign pins_out = (oval_q & oe_q) ^ inv_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [REG_ADDR_W-1:0]       req_addr,
  input logic                        rsp_valid,
  input logic [W-1:0]                pins_out,
  input logic                        irq,
  input logic [W-1:0]                in_en,
  input logic [NUM_KINDS-1:0][W-1:0] pend
);
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_k
    // R5: pending bits fall only on a write to their own register
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_addr == pend_ofs(k))
      |=> ((pend[k] & $past(pend[k])) == $past(pend[k])));
    // R3 / R4: newly set pending bits need their input enable
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend[k] & ~$past(pend[k]) & ~$past(in_en)) == '0));
  end

  // R6: the interrupt can only drop after a bus write
  p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(req_valid && req_write));

  // R7: driven pins hold unless a write was taken
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(pins_out));

  // R9: read response timing
  p_rsp_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.W(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .pins_out(pins_out),
  .irq(irq), .in_en(in_en_q), .pend(pend_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pins_in = '0;
  logic [31:0] pins_out;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pins_in(pins_in), .pins_out(pins_out), .irq(irq)
  );

  // reference model
  logic [31:0] m_in_en, m_oe, m_out, m_pull, m_drv, m_inv, m_pins;
  logic [31:0] m_ie [4];
  logic [31:0] m_p  [4];

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a >= 7'h18 && a <= 7'h37) begin
      if (a[2]) return m_p[(a - 7'h18) >> 3];
      else      return m_ie[(a - 7'h18) >> 3];
    end
    case (a)
      7'h00: return m_pins & m_in_en;
      7'h04: return m_in_en;
      7'h08: return m_oe;
      7'h0C: return m_out;
      7'h10: return m_pull;
      7'h14: return m_drv;
      7'h40: return m_inv;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int k = 0; k < 4; k++) r |= |(m_p[k] & m_ie[k]);
    return r;
  endfunction

  task automatic apply_levels();
    m_p[2] |= m_pins & m_in_en;
    m_p[3] |= ~m_pins & m_in_en;
  endtask

  task automatic model_write(input logic [6:0] a, input logic [31:0] d);
    if (a[1:0] != 2'b00) return;
    if (a >= 7'h18 && a <= 7'h37) begin
      if (a[2]) m_p[(a - 7'h18) >> 3] &= ~d;
      else      m_ie[(a - 7'h18) >> 3] = d;
    end else begin
      case (a)
        7'h04: m_in_en = d;
        7'h08: m_oe = d;
        7'h0C: m_out = d;
        7'h10: m_pull = d;
        7'h14: m_drv = d;
        7'h40: m_inv = d;
        default: ;
      endcase
    end
    apply_levels();
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    repeat (2) @(negedge clk);
    model_write(a, d);
  endtask

  task automatic do_read(input logic [6:0] a, output logic [31:0] d, output logic v);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 0;
  endtask

  task automatic set_pins(input logic [31:0] p);
    logic [31:0] old = m_pins;
    pins_in = p;
    repeat (4) @(negedge clk);
    m_p[0] |= p & ~old & m_in_en;
    m_p[1] |= ~p & old & m_in_en;
    m_pins = p;
    apply_levels();
  endtask

  task automatic check_outs(input string tag);
    chk("R6", {tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    chk("R7", {tag, " pins_out"}, pins_out, (m_out & m_oe) ^ m_inv);
  endtask

  task automatic read_check(input string req, input logic [6:0] a);
    logic [31:0] d; logic v;
    do_read(a, d, v);
    chk(req, $sformatf("read %h", a), d, exp_read(a));
    chk("R9", "rsp_valid after read", {31'b0, v}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d; logic v;
    logic [6:0] rd_list [12];
    m_in_en = 0; m_oe = 0; m_out = 0; m_pull = 0; m_drv = 0; m_inv = 0; m_pins = 0;
    for (int k = 0; k < 4; k++) begin m_ie[k] = 0; m_p[k] = 0; end
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "reset irq", {31'b0, irq}, 32'd0);
    chk("R1", "reset pins_out", pins_out, 32'd0);
    chk("R9", "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    for (int a = 0; a < 7'h44; a += 4) read_check("R1", 7'(a));
    @(negedge clk);
    chk("R9", "rsp_valid drops after read", {31'b0, rsp_valid}, 32'd0);

    // R1 read-back of written registers
    do_write(7'h08, 32'hA5A5_0F0F); read_check("R1", 7'h08);
    do_write(7'h10, 32'h1234_5678); read_check("R1", 7'h10);
    do_write(7'h14, 32'hCAFE_F00D); read_check("R1", 7'h14);
    do_write(7'h0C, 32'hFFFF_0000); read_check("R1", 7'h0C);

    // R7 invert acts on disabled pins too
    do_write(7'h40, 32'h0000_00FF);
    check_outs("R7 invert");
    chk("R7", "invert on disabled pin 0", {31'b0, pins_out[0]}, 32'd1);

    // R2 synchronizer latency and input mask
    do_write(7'h04, 32'h0000_FFFF);
    pins_in = 32'h00F0_00F0;
    do_read(7'h00, d, v);
    chk("R2", "level before sync", d, 32'h0);
    repeat (4) @(negedge clk);
    m_p[0] |= 32'h00F0_00F0 & m_in_en;
    m_pins = 32'h00F0_00F0; apply_levels();
    read_check("R2", 7'h00);
    chk("R2", "masked level", exp_read(7'h00), 32'h0000_00F0);

    // R3 edges, only where input enabled
    read_check("R3", 7'h1C);
    chk("R3", "rise model", m_p[0], 32'h0000_00F0);
    set_pins(32'h0000_0000);
    read_check("R3", 7'h24);
    chk("R3", "fall model", m_p[1], 32'h0000_00F0);

    // R4 levels
    read_check("R4", 7'h2C);
    read_check("R4", 7'h34);

    // R5 clear and set-wins
    set_pins(32'h0000_0001);
    do_write(7'h2C, 32'hFFFF_FFFF);
    read_check("R5", 7'h2C);
    chk("R5", "high stays set while pin high", m_p[2], 32'h0000_0001);
    do_write(7'h1C, 32'h0000_0010);
    read_check("R5", 7'h1C);

    // R6 interrupt gating
    check_outs("R6 no enables");
    do_write(7'h18, 32'h0000_0001);
    check_outs("R6 rise enabled");
    chk("R6", "irq asserted", {31'b0, irq}, 32'd1);
    do_write(7'h1C, 32'h0000_0001);
    check_outs("R6 rise cleared");
    do_write(7'h18, 32'h0);

    // R8 unmapped, unaligned and input-register writes
    do_write(7'h00, 32'hFFFF_FFFF);
    do_write(7'h05, 32'h0);
    do_write(7'h38, 32'hFFFF_FFFF);
    read_check("R8", 7'h04);
    read_check("R8", 7'h05);
    read_check("R8", 7'h38);
    read_check("R8", 7'h44);
    read_check("R8", 7'h7C);
    read_check("R8", 7'h00);

    // random phase
    rd_list = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h1C, 7'h24, 7'h2C,
                7'h34, 7'h18, 7'h30, 7'h40, 7'h3C};
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 4);
      case (op)
        0: set_pins(($urandom % 2) ? $urandom : (m_pins ^ (32'h1 << ($urandom % 32))));
        1: begin
          logic [6:0] a = 7'(4 * ($urandom % 17));
          if (($urandom % 8) == 0) a = a + 7'd2;
          do_write(a, $urandom);
        end
        2: read_check("R5", rd_list[$urandom % 12]);
        default: @(negedge clk);
      endcase
      check_outs("random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule